// File: doc/BRIEF.md
# Reservation Station Array with Wakeup and Select

This block holds up to four in-flight instructions for an out-of-order core. Each slot keeps an opcode, a destination register number and two source operands. Each operand is held either as a ready 32-bit value or as the index of the slot whose result it is waiting for. Every functional unit drives its own result bus: a valid bit, a producer slot index and a data word. Every waiting operand watches all buses at once. When an operand sees its producer's index, it replaces the index with the data.

Each cycle the array offers at most one instruction to execution. It picks the lowest-numbered slot whose operands are both values and whose functional unit is not busy. An issued slot stays occupied, marked as executing, until a result bus carries its own index, and is then freed. New work goes into the lowest free slot. A stall output blocks dispatch while all slots are full.

Each slot runs a four-state machine. `ST_IDLE` is free. `ST_WAIT` holds at least one pending operand. `ST_RDY` has both operands resolved. `ST_EXEC` has issued and waits for its own result. The transitions are:
- alloc: `ST_IDLE` to `ST_WAIT`, or to `ST_RDY` when nothing is pending after same-cycle wakeup.
- resolve: `ST_WAIT` to `ST_RDY`.
- grant: `ST_RDY` to `ST_EXEC`.
- release: `ST_EXEC` to `ST_IDLE`.

Top module: `rs_array`

## Requirements
- R1: After reset all four slots are free: `stall` is 0, `issue_valid` is 0 and `alloc_id` is 0.
- R2: A dispatch is accepted when `disp_valid` is 1 and `stall` is 0. It is written into the lowest-numbered free slot, whose index is shown on `alloc_id` in the same cycle (0 when no slot is free).
- R3: Operand tag flag encoding: 1 means the low 2 bits of the operand field name the producer slot, 0 means the field is a value. A pending operand takes `res_data` of any bus u with `res_valid[u]` set and `res_tag[2u+1:2u]` equal to its producer index. When several buses match in one cycle, the lowest-numbered bus wins.
- R4: Result buses present in the same cycle as a dispatch are also matched against the incoming operand tags, so that wakeup is not lost.
- R5: Opcode to unit mapping: 0 and 1 go to unit 0, 2 to unit 1, 3 to unit 2, any other code to unit 0. A slot is eligible only when both operands are values and `fu_busy` of its unit is 0.
- R6: At most one instruction issues per cycle, taken from the lowest-indexed eligible slot. The issue outputs carry that slot's opcode, destination, both operand values, slot index and unit.
- R7: An issued slot cannot issue again. It stays occupied until a valid result bus carries its own index, and is free from the next cycle.
- R8: `stall` is 1 exactly when all four slots are occupied. A dispatch presented while `stall` is 1 is ignored.
- R9: A captured operand takes part in selection from the cycle after its broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | 4 | Opcode of dispatched instruction |
| disp_dst | input | 4 | Destination register number |
| disp_a_tag | input | 1 | Operand A is a producer tag (1) or a value (0) |
| disp_a | input | 32 | Operand A value, or tag in bits 1:0 |
| disp_b_tag | input | 1 | Operand B is a producer tag (1) or a value (0) |
| disp_b | input | 32 | Operand B value, or tag in bits 1:0 |
| fu_busy | input | 3 | Per-unit busy flags |
| res_valid | input | 3 | Per-unit result bus valid |
| res_tag | input | 6 | Per-unit producer slot index, 2 bits per unit |
| res_data | input | 96 | Per-unit result data, 32 bits per unit |
| stall | output | 1 | All slots occupied |
| alloc_id | output | 2 | Slot a dispatch goes into this cycle |
| issue_valid | output | 1 | An instruction is issued this cycle |
| issue_tag | output | 2 | Index of the issued slot |
| issue_unit | output | 2 | Target unit of the issued instruction |
| issue_op | output | 4 | Issued opcode |
| issue_dst | output | 4 | Issued destination register |
| issue_a | output | 32 | Issued operand A value |
| issue_b | output | 32 | Issued operand B value |

## Verification
Some internal faults only show later. A missed or wrong wakeup leaves a slot in `ST_WAIT`, so an expected issue never appears, or a wrong `issue_a`/`issue_b` word appears when the slot is selected, often many cycles after the broadcast. A slot that fails to leave `ST_EXEC` shows up within a cycle as a wrong `alloc_id` or an early `stall`. A slot that leaves `ST_EXEC` early or repeats an issue shows up as an extra `issue_valid` with a repeated `issue_tag`. The bench therefore compares every output in every cycle against a model of all four slots, so each fault is caught at the first cycle it reaches a port.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int UNIT_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RDY  = 2'd2,
        ST_EXEC = 2'd3
    } slot_state_t;

    // opcode to functional unit: add/sub -> 0, mul -> 1, div -> 2
    function automatic logic [UNIT_W-1:0] unit_of(input logic [3:0] op);
        unique case (op)
            4'd2:    return 2'd1;
            4'd3:    return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
#(
    parameter int IDX  = 0,
    parameter int N_FU = 3,
    parameter int DW   = 32,
    parameter int OPW  = 4,
    parameter int RW   = 4,
    parameter int TW   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc,
    input  logic                 grant,
    input  logic [OPW-1:0]       d_op,
    input  logic [RW-1:0]        d_dst,
    input  logic                 d_a_tag,
    input  logic [DW-1:0]        d_a,
    input  logic                 d_b_tag,
    input  logic [DW-1:0]        d_b,
    input  logic [N_FU-1:0]      r_valid,
    input  logic [N_FU*TW-1:0]   r_tag,
    input  logic [N_FU*DW-1:0]   r_data,
    output logic                 busy,
    output logic                 ready,
    output logic [UNIT_W-1:0]    unit,
    output logic [OPW-1:0]       op,
    output logic [RW-1:0]        dst,
    output logic [DW-1:0]        a_val,
    output logic [DW-1:0]        b_val
);

    slot_state_t state, state_n;
    logic          a_pend, b_pend;
    logic [DW-1:0] a_q, b_q;
    logic          da_p, db_p, sa_p, sb_p, rel;
    logic [DW-1:0] da_v, db_v, sa_v, sb_v;

    // snoop all buses; first matching bus supplies the value
    function automatic logic [DW:0] snoop(
        input logic                pend,
        input logic [DW-1:0]       v,
        input logic [N_FU-1:0]     rv,
        input logic [N_FU*TW-1:0]  rt,
        input logic [N_FU*DW-1:0]  rd
    );
        logic          p;
        logic [DW-1:0] x;
        p = pend;
        x = v;
        for (int u = 0; u < N_FU; u++) begin
            if (p && rv[u] && rt[u*TW +: TW] == x[TW-1:0]) begin
                x = rd[u*DW +: DW];
                p = 1'b0;
            end
        end
        return {p, x};
    endfunction

    always_comb begin
        {da_p, da_v} = snoop(d_a_tag, d_a, r_valid, r_tag, r_data);
        {db_p, db_v} = snoop(d_b_tag, d_b, r_valid, r_tag, r_data);
        {sa_p, sa_v} = snoop(a_pend, a_q, r_valid, r_tag, r_data);
        {sb_p, sb_v} = snoop(b_pend, b_q, r_valid, r_tag, r_data);
        rel = 1'b0;
        for (int u = 0; u < N_FU; u++) begin
            if (r_valid[u] && r_tag[u*TW +: TW] == TW'(IDX)) rel = 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (alloc)          state_n = (da_p || db_p) ? ST_WAIT : ST_RDY;
            ST_WAIT: if (!sa_p && !sb_p) state_n = ST_RDY;
            ST_RDY:  if (grant)          state_n = ST_EXEC;
            ST_EXEC: if (rel)            state_n = ST_IDLE;
            default:                     state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // slot contents
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op     <= '0;
            dst    <= '0;
            a_pend <= 1'b0;
            b_pend <= 1'b0;
            a_q    <= '0;
            b_q    <= '0;
        end else if (state == ST_IDLE && alloc) begin
            op     <= d_op;
            dst    <= d_dst;
            a_pend <= da_p;
            b_pend <= db_p;
            a_q    <= da_v;
            b_q    <= db_v;
        end else if (state == ST_WAIT) begin
            a_pend <= sa_p;
            b_pend <= sb_p;
            a_q    <= sa_v;
            b_q    <= sb_v;
        end
    end

    assign busy  = (state != ST_IDLE);
    assign ready = (state == ST_RDY);
    assign unit  = unit_of(op);
    assign a_val = a_q;
    assign b_val = b_q;

endmodule

// File: rtl/rs_pick.sv
module rs_pick
    import rs_pkg::*;
#(
    parameter int N    = 4,
    parameter int N_FU = 3,
    parameter int TW   = 2
) (
    input  logic [N-1:0]        busy,
    input  logic [N-1:0]        ready,
    input  logic [N*UNIT_W-1:0] units,
    input  logic [N_FU-1:0]     fu_busy,
    output logic                free_hit,
    output logic [TW-1:0]       free_idx,
    output logic                pick_hit,
    output logic [TW-1:0]       pick_idx,
    output logic [N-1:0]        pick_oh
);

    localparam int NU = 1 << UNIT_W;
    logic [NU-1:0] fb;

    always_comb begin
        fb       = NU'(fu_busy);
        free_hit = 1'b0;
        free_idx = '0;
        pick_hit = 1'b0;
        pick_idx = '0;
        pick_oh  = '0;
        // scan downward so the lowest index is the last writer
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                free_hit = 1'b1;
                free_idx = TW'(i);
            end
            if (ready[i] && !fb[units[i*UNIT_W +: UNIT_W]]) begin
                pick_hit = 1'b1;
                pick_idx = TW'(i);
            end
        end
        if (pick_hit) pick_oh[pick_idx] = 1'b1;
    end

endmodule

// File: rtl/rs_array.sv
module rs_array
    import rs_pkg::*;
#(
    parameter int N_ENT = 4,
    parameter int N_FU  = 3,
    parameter int DW    = 32,
    parameter int OPW   = 4,
    parameter int RW    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 disp_valid,
    input  logic [OPW-1:0]       disp_op,
    input  logic [RW-1:0]        disp_dst,
    input  logic                 disp_a_tag,
    input  logic [DW-1:0]        disp_a,
    input  logic                 disp_b_tag,
    input  logic [DW-1:0]        disp_b,
    input  logic [N_FU-1:0]      fu_busy,
    input  logic [N_FU-1:0]      res_valid,
    input  logic [N_FU*$clog2(N_ENT)-1:0] res_tag,
    input  logic [N_FU*DW-1:0]   res_data,
    output logic                 stall,
    output logic [$clog2(N_ENT)-1:0] alloc_id,
    output logic                 issue_valid,
    output logic [$clog2(N_ENT)-1:0] issue_tag,
    output logic [UNIT_W-1:0]    issue_unit,
    output logic [OPW-1:0]       issue_op,
    output logic [RW-1:0]        issue_dst,
    output logic [DW-1:0]        issue_a,
    output logic [DW-1:0]        issue_b
);

    localparam int TW = $clog2(N_ENT);

    logic [N_ENT-1:0]        ent_busy, ent_ready, ent_grant;
    logic [N_ENT*UNIT_W-1:0] ent_unit;
    logic [OPW-1:0]          ent_op  [N_ENT];
    logic [RW-1:0]           ent_dst [N_ENT];
    logic [DW-1:0]           ent_a   [N_ENT];
    logic [DW-1:0]           ent_b   [N_ENT];
    logic                    free_hit, pick_hit, accept;
    logic [TW-1:0]           free_idx, pick_idx;

    assign stall  = &ent_busy;
    assign accept = disp_valid && !stall;

    rs_pick #(.N(N_ENT), .N_FU(N_FU), .TW(TW)) u_pick (
        .busy     (ent_busy),
        .ready    (ent_ready),
        .units    (ent_unit),
        .fu_busy  (fu_busy),
        .free_hit (free_hit),
        .free_idx (free_idx),
        .pick_hit (pick_hit),
        .pick_idx (pick_idx),
        .pick_oh  (ent_grant)
    );

    for (genvar g = 0; g < N_ENT; g++) begin : g_slot
        rs_slot #(
            .IDX(g), .N_FU(N_FU), .DW(DW), .OPW(OPW), .RW(RW), .TW(TW)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .alloc   (accept && free_hit && free_idx == TW'(g)),
            .grant   (ent_grant[g]),
            .d_op    (disp_op),
            .d_dst   (disp_dst),
            .d_a_tag (disp_a_tag),
            .d_a     (disp_a),
            .d_b_tag (disp_b_tag),
            .d_b     (disp_b),
            .r_valid (res_valid),
            .r_tag   (res_tag),
            .r_data  (res_data),
            .busy    (ent_busy[g]),
            .ready   (ent_ready[g]),
            .unit    (ent_unit[g*UNIT_W +: UNIT_W]),
            .op      (ent_op[g]),
            .dst     (ent_dst[g]),
            .a_val   (ent_a[g]),
            .b_val   (ent_b[g])
        );
    end

    assign alloc_id    = free_idx;
    assign issue_valid = pick_hit;
    assign issue_tag   = pick_idx;
    assign issue_unit  = ent_unit[pick_idx*UNIT_W +: UNIT_W];
    assign issue_op    = ent_op[pick_idx];
    assign issue_dst   = ent_dst[pick_idx];
    assign issue_a     = ent_a[pick_idx];
    assign issue_b     = ent_b[pick_idx];

endmodule

// File: rtl/rs_array_chk.sv
module rs_array_chk #(
    parameter int N    = 4,
    parameter int N_FU = 3,
    parameter int TW   = 2,
    parameter int UW   = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            disp_valid,
    input logic            stall,
    input logic [TW-1:0]   alloc_id,
    input logic [N_FU-1:0] fu_busy,
    input logic            issue_valid,
    input logic [TW-1:0]   issue_tag,
    input logic [UW-1:0]   issue_unit,
    input logic [N-1:0]    ent_busy
);

    localparam int NU = 1 << UW;
    logic [NU-1:0] fb;
    assign fb = NU'(fu_busy);

    // R1: first cycle out of reset shows no stall and no issue
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!stall && !issue_valid));

    // R5: issued work targets a unit that is free
    a_r5_unit_free: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !fb[issue_unit]);

    // R6: issued slot is an occupied slot
    a_r6_issue_occupied: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> ent_busy[issue_tag]);

    // R7: a slot never issues in two consecutive cycles
    a_r7_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> !(issue_valid && issue_tag == $past(issue_tag)));

    // R2: accepted dispatch occupies the announced slot
    a_r2_alloc_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !stall) |=> ent_busy[$past(alloc_id)]);

    // R8: occupancy grows by at most one slot per cycle
    a_r8_grow_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(rst_n) |-> ($countones(ent_busy) <= $countones($past(ent_busy)) + 1));

endmodule

bind rs_array rs_array_chk #(
    .N(N_ENT), .N_FU(N_FU), .TW($clog2(N_ENT)), .UW(rs_pkg::UNIT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .disp_valid  (disp_valid),
    .stall       (stall),
    .alloc_id    (alloc_id),
    .fu_busy     (fu_busy),
    .issue_valid (issue_valid),
    .issue_tag   (issue_tag),
    .issue_unit  (issue_unit),
    .ent_busy    (ent_busy)
);

// File: tb/sim_rs_array.sv
`timescale 1ns/1ps
module sim_rs_array;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid = 1'b0;
    logic [3:0]  disp_op = '0, disp_dst = '0;
    logic        disp_a_tag = 1'b0, disp_b_tag = 1'b0;
    logic [31:0] disp_a = '0, disp_b = '0;
    logic [2:0]  fu_busy = '0, res_valid = '0;
    logic [5:0]  res_tag = '0;
    logic [95:0] res_data = '0;
    logic        stall, issue_valid;
    logic [1:0]  alloc_id, issue_tag, issue_unit;
    logic [3:0]  issue_op, issue_dst;
    logic [31:0] issue_a, issue_b;

    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rs_array u0 (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_op(disp_op),
        .disp_dst(disp_dst), .disp_a_tag(disp_a_tag), .disp_a(disp_a),
        .disp_b_tag(disp_b_tag), .disp_b(disp_b), .fu_busy(fu_busy),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
        .stall(stall), .alloc_id(alloc_id), .issue_valid(issue_valid),
        .issue_tag(issue_tag), .issue_unit(issue_unit), .issue_op(issue_op),
        .issue_dst(issue_dst), .issue_a(issue_a), .issue_b(issue_b)
    );

    // model: 0 free, 1 waiting, 2 ready, 3 executing
    int          m_st [4];
    logic [3:0]  m_op [4], m_dst [4];
    logic        m_ap [4], m_bp [4];
    logic [31:0] m_av [4], m_bv [4];
    int          e_alloc, e_grant;
    bit          e_stall;

    function automatic int unit_of(input logic [3:0] op);
        if (op == 4'd2) return 1;
        if (op == 4'd3) return 2;
        return 0;
    endfunction

    function automatic logic [32:0] mwake(input logic p, input logic [31:0] v);
        logic pp = p;
        logic [31:0] vv = v;
        for (int u = 0; u < 3; u++)
            if (pp && res_valid[u] && res_tag[u*2 +: 2] == vv[1:0]) begin
                vv = res_data[u*32 +: 32];
                pp = 1'b0;
            end
        return {pp, vv};
    endfunction

    task automatic chk(input string req, input string ctx, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s (%s) act=%0h exp=%0h", req, ctx, act, exp);
        end
    endtask

    task automatic compare(input string ctx);
        e_stall = 1; e_alloc = 0; e_grant = -1;
        for (int i = 3; i >= 0; i--) begin
            if (m_st[i] == 0) begin e_stall = 0; e_alloc = i; end
            if (m_st[i] == 2 && !fu_busy[unit_of(m_op[i])]) e_grant = i;
        end
        chk("R8 stall", ctx, 32'(stall), 32'(e_stall));
        chk("R2 alloc_id", ctx, 32'(alloc_id), 32'(e_alloc));
        chk("R6 issue_valid", ctx, 32'(issue_valid), 32'(e_grant >= 0));
        if (e_grant >= 0 && issue_valid === 1'b1) begin
            chk("R6 issue_tag", ctx, 32'(issue_tag), 32'(e_grant));
            chk("R5 issue_unit", ctx, 32'(issue_unit), 32'(unit_of(m_op[e_grant])));
            chk("R6 issue_op", ctx, 32'(issue_op), 32'(m_op[e_grant]));
            chk("R6 issue_dst", ctx, 32'(issue_dst), 32'(m_dst[e_grant]));
            chk("R3 issue_a", ctx, issue_a, m_av[e_grant]);
            chk("R3 issue_b", ctx, issue_b, m_bv[e_grant]);
        end
    endtask

    task automatic model_step();
        for (int i = 0; i < 4; i++) begin
            case (m_st[i])
                3: for (int u = 0; u < 3; u++)
                       if (res_valid[u] && res_tag[u*2 +: 2] == 2'(i)) m_st[i] = 0;
                2: if (i == e_grant) m_st[i] = 3;
                1: begin
                    {m_ap[i], m_av[i]} = mwake(m_ap[i], m_av[i]);
                    {m_bp[i], m_bv[i]} = mwake(m_bp[i], m_bv[i]);
                    if (!m_ap[i] && !m_bp[i]) m_st[i] = 2;
                end
                default: if (disp_valid && !e_stall && i == e_alloc) begin
                    m_op[i]  = disp_op;
                    m_dst[i] = disp_dst;
                    {m_ap[i], m_av[i]} = mwake(disp_a_tag, disp_a);
                    {m_bp[i], m_bv[i]} = mwake(disp_b_tag, disp_b);
                    m_st[i] = (m_ap[i] || m_bp[i]) ? 1 : 2;
                end
            endcase
        end
    endtask

    task automatic step(input string ctx,
                        input logic dv, input logic [3:0] op, input logic [3:0] dst,
                        input logic at, input logic [31:0] a, input logic bt, input logic [31:0] b,
                        input logic [2:0] fb, input logic [2:0] rv, input logic [5:0] rt,
                        input logic [95:0] rd);
        @(negedge clk);
        disp_valid = dv; disp_op = op; disp_dst = dst;
        disp_a_tag = at; disp_a = a; disp_b_tag = bt; disp_b = b;
        fu_busy = fb; res_valid = rv; res_tag = rt; res_data = rd;
        #1;
        compare(ctx);
        model_step();
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        for (int i = 0; i < 4; i++) begin
            m_st[i] = 0; m_op[i] = '0; m_dst[i] = '0;
            m_ap[i] = 0; m_bp[i] = 0; m_av[i] = '0; m_bv[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 stall", "reset", 32'(stall), 0);
        chk("R1 issue_valid", "reset", 32'(issue_valid), 0);
        chk("R1 alloc_id", "reset", 32'(alloc_id), 0);

        // R8: fill all slots with units busy, then a dispatch that must be ignored
        for (int k = 0; k < 4; k++)
            step("R8 fill", 1, 4'(k), 4'(k + 8), 0, 32'(100 + k), 0, 32'(200 + k),
                 3'b111, 0, 0, 0);
        step("R8 ignored", 1, 4'd1, 4'd15, 0, 32'hdead, 0, 32'hbeef, 3'b111, 0, 0, 0);
        step("R8 still full", 0, 0, 0, 0, 0, 0, 0, 3'b111, 0, 0, 0);

        // R6/R7: units freed, one issue per cycle in slot order
        for (int k = 0; k < 4; k++)
            step("R6 order", 0, 0, 0, 0, 0, 0, 0, 3'b000, 0, 0, 0);
        step("R7 no reissue", 0, 0, 0, 0, 0, 0, 0, 3'b000, 0, 0, 0);
        step("R7 release slot2", 0, 0, 0, 0, 0, 0, 0, 3'b000, 3'b001, 6'b000010, 96'h5);
        // R4: dispatch into slot 2 waiting on slot 1, whose result arrives the same cycle on bus 1
        step("R4 same-cycle wake", 1, 4'd0, 4'd3, 1, 32'd1, 0, 32'd7, 3'b000,
             3'b010, 6'b000100, {32'd0, 32'h1234, 32'd0});
        step("R4 issue woken", 0, 0, 0, 0, 0, 0, 0, 3'b000, 0, 0, 0);
        // R3: two buses carry the same tag; lowest bus wins
        step("R3 wait on 1", 1, 4'd2, 4'd4, 1, 32'd1, 1, 32'd3, 3'b000, 0, 0, 0);
        step("R3 bus priority", 0, 0, 0, 0, 0, 0, 0, 3'b000,
             3'b011, 6'b000101, {32'd0, 32'haaaa, 32'hbbbb});
        step("R9 next cycle", 0, 0, 0, 0, 0, 0, 0, 3'b000, 3'b100, 6'b110000, {32'hcccc, 64'd0});
        step("R9 issue", 0, 0, 0, 0, 0, 0, 0, 3'b000, 0, 0, 0);

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] op;
            logic [5:0] rt;
            logic [2:0] rv, fb;
            op = ($urandom % 6 == 0) ? 4'h9 : 4'($urandom % 4);
            rt = 6'($urandom);
            rv = {($urandom % 4 == 0), ($urandom % 4 == 0), ($urandom % 4 == 0)};
            fb = {($urandom % 3 == 0), ($urandom % 3 == 0), ($urandom % 3 == 0)};
            step("R9 random", ($urandom % 5 < 3), op, 4'($urandom),
                 ($urandom % 5 < 2), $urandom, ($urandom % 5 < 2), $urandom,
                 fb, rv, rt, {$urandom, $urandom, $urandom});
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule